// File: doc/BRIEF.md
# Element-Width Overlay Register File

This block is a bank of 64-bit scalar registers that can also be addressed as one long packed array of 8-, 16-, 32- or 64-bit elements. Each access names a base register, an element index and an element width. The block turns these three values into a flat byte position, `base*8 + index*(width/8)`. The register that holds the element is that position divided by eight, and the byte lane where the element starts is the position modulo eight. An element whose index runs past the end of the base register continues into the next-numbered registers. Software relies on this overflow layout, so it is fixed.

There is one read port and one write port, and each has its own width select. Reads are combinational and return the element zero-extended to 64 bits. A write lands on the rising clock edge. It touches only the byte lanes of the addressed element, so the other elements in the same register keep their values. A flat position past the last register wraps modulo the size of the file. When that happens the port raises a wrap flag.

Top module: `elem_overlay_rf`

## Requirements
- R1: The width select codes an element width per access: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64.
- R2: Element 0 occupies the least-significant byte lanes of the base register. Element n begins at byte lane n*(width/8) counted upward from there, with little-endian byte order and LSB0 bit numbering.
- R3: An element whose byte position is beyond the base register lies in register `base + (position div 8)` at lane `position mod 8`. The same storage is reachable through any base and index pair that gives the same byte position.
- R4: The read data carries the selected element in its low bits, and every bit above the element width reads as zero.
- R5: A write changes only the byte lanes of the addressed element. Every other byte of the file keeps its value.
- R6: Storage changes only at a rising clock edge where the write enable is high. With the write enable low, driving the other write inputs has no effect.
- R7: A flat byte position of 256 or more wraps modulo 256 bytes. When it wraps, the port's wrap flag (`rd_wrap` or `wr_wrap`) is high; otherwise the flag is low.
- R8: A synchronous reset, held high across a rising edge, clears every register to zero.
- R9: Width 64 with index 0 reads or writes the base register as a whole 64-bit scalar.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_base | input | 5 | Write base register number |
| wr_idx | input | 8 | Write element index |
| wr_wsel | input | 2 | Write element width code |
| wr_data | input | 64 | Write element value in its low bits |
| wr_wrap | output | 1 | Write position wrapped past the last register |
| rd_base | input | 5 | Read base register number |
| rd_idx | input | 8 | Read element index |
| rd_wsel | input | 2 | Read element width code |
| rd_data | output | 64 | Zero-extended read element |
| rd_wrap | output | 1 | Read position wrapped past the last register |

## Verification
Read data is combinational. A wrong row, lane offset or width mask therefore shows up on `rd_data` in the same cycle as the access that hits it. A corrupted byte lane in storage stays hidden until some read covers that byte. So after each write the bench reads both the element itself and the whole 64-bit register around it. It also reads the same bytes through a different base and index, which catches both a neighbour-clobbering write enable and a wrong overflow mapping on the next read. A fault in the wrap logic shows at once on the flag, and it also shows one cycle later as data in the wrong register.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  // element width codes carried on the width-select pins
  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ew_e;

  localparam int unsigned LANE_BITS = 8;
endpackage

// File: rtl/ovl_addr_map.sv
module ovl_addr_map #(
  parameter int NREG  = 32,
  parameter int IDXW  = 8,
  parameter int NLANE = 8
) (
  input  logic [$clog2(NREG)-1:0]  base,
  input  logic [IDXW-1:0]          idx,
  input  logic [1:0]               wsel,
  output logic [$clog2(NREG)-1:0]  row,
  output logic [$clog2(NLANE)-1:0] off,
  output logic                     wrap
);
  localparam int REGW  = $clog2(NREG);
  localparam int OFFW  = $clog2(NLANE);
  localparam int FLATW = REGW + OFFW;
  localparam int SUMW  = FLATW + IDXW + 1;

  logic [SUMW-1:0] flat;

  // byte position = base*lanes + idx*(element bytes)
  always_comb begin
    flat = SUMW'({base, {OFFW{1'b0}}}) + (SUMW'(idx) << wsel);
    wrap = |flat[SUMW-1:FLATW];
    row  = flat[FLATW-1:OFFW];
    off  = flat[OFFW-1:0];
  end
endmodule

// File: rtl/ovl_lane.sv
module ovl_lane #(
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [7:0]              wdata,
  input  logic [$clog2(NREG)-1:0] raddr,
  output logic [7:0]              rdata
);
  logic [7:0] store [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) store[r] <= 8'h00;
    end else if (we) begin
      store[waddr] <= wdata;
    end
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/ovl_read_align.sv
module ovl_read_align
  import ovl_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0]             row_data,
  input  logic [$clog2(DW/8)-1:0]   off,
  input  logic [1:0]                wsel,
  output logic [DW-1:0]             elem
);
  logic [DW-1:0] shifted;
  logic [DW-1:0] keep;
  int            nbits;

  always_comb begin
    case (ew_e'(wsel))
      EW8:     nbits = 8;
      EW16:    nbits = 16;
      EW32:    nbits = 32;
      default: nbits = 64;
    endcase
    shifted = row_data >> {off, 3'b000};
    for (int i = 0; i < DW; i++) keep[i] = (i < nbits);
    elem = shifted & keep;
  end
endmodule

// File: rtl/elem_overlay_rf.sv
module elem_overlay_rf #(
  parameter int NREG = 32,
  parameter int IDXW = 8,
  parameter int DW   = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_base,
  input  logic [IDXW-1:0]         wr_idx,
  input  logic [1:0]              wr_wsel,
  input  logic [DW-1:0]           wr_data,
  output logic                    wr_wrap,
  input  logic [$clog2(NREG)-1:0] rd_base,
  input  logic [IDXW-1:0]         rd_idx,
  input  logic [1:0]              rd_wsel,
  output logic [DW-1:0]           rd_data,
  output logic                    rd_wrap
);
  localparam int NLANE = DW / 8;
  localparam int OFFW  = $clog2(NLANE);
  localparam int REGW  = $clog2(NREG);

  logic [REGW-1:0]  w_row, r_row;
  logic [OFFW-1:0]  w_off, r_off;
  logic [NLANE-1:0] lane_we;
  logic [DW-1:0]    w_shift;
  logic [DW-1:0]    r_row_data;

  ovl_addr_map #(.NREG(NREG), .IDXW(IDXW), .NLANE(NLANE)) u_wmap (
    .base(wr_base), .idx(wr_idx), .wsel(wr_wsel),
    .row(w_row), .off(w_off), .wrap(wr_wrap)
  );

  ovl_addr_map #(.NREG(NREG), .IDXW(IDXW), .NLANE(NLANE)) u_rmap (
    .base(rd_base), .idx(rd_idx), .wsel(rd_wsel),
    .row(r_row), .off(r_off), .wrap(rd_wrap)
  );

  // per-lane write enables cover only the addressed element's bytes
  always_comb begin
    int nbytes;
    nbytes  = 1 << rd_wsel_dummy(wr_wsel);
    w_shift = wr_data << {w_off, 3'b000};
    for (int l = 0; l < NLANE; l++)
      lane_we[l] = wr_en && (l >= int'(w_off)) && (l < int'(w_off) + nbytes);
  end

  function automatic int rd_wsel_dummy(input logic [1:0] code);
    return int'(code);
  endfunction

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    ovl_lane #(.NREG(NREG)) u_lane (
      .clk(clk), .rst(rst), .we(lane_we[l]),
      .waddr(w_row), .wdata(w_shift[8*l +: 8]),
      .raddr(r_row), .rdata(r_row_data[8*l +: 8])
    );
  end

  ovl_read_align #(.DW(DW)) u_align (
    .row_data(r_row_data), .off(r_off), .wsel(rd_wsel), .elem(rd_data)
  );
endmodule

// File: rtl/ovl_checker.sv
module ovl_checker
  import ovl_pkg::*;
#(
  parameter int NREG = 32,
  parameter int IDXW = 8,
  parameter int DW   = 64
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic [$clog2(NREG)-1:0] wr_base,
  input logic [IDXW-1:0]         wr_idx,
  input logic [1:0]              wr_wsel,
  input logic [DW-1:0]           wr_data,
  input logic                    wr_wrap,
  input logic [$clog2(NREG)-1:0] rd_base,
  input logic [IDXW-1:0]         rd_idx,
  input logic [1:0]              rd_wsel,
  input logic [DW-1:0]           rd_data,
  input logic                    rd_wrap
);
  // R8: the cycle after a reset edge every location reads zero
  p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0));

  // R4: bits above the element width are zero
  p_zero_ext_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_wsel != EW64) |-> ((rd_data >> (7'd8 << rd_wsel)) == '0));

  // R6: no write and no reset -> same read address gives same data
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(rst) && $stable(rd_base) && $stable(rd_idx)
     && $stable(rd_wsel)) |-> $stable(rd_data));

  // R5: reading back what was just written at the same element
  p_readback_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(rst) && rd_base == $past(wr_base)
     && rd_idx == $past(wr_idx) && rd_wsel == $past(wr_wsel))
    |-> (rd_data == ($past(wr_data) & ~({DW{1'b1}} << (7'd8 << rd_wsel)))));

  // R7: a 64-bit element past the last register must flag a wrap
  p_wrap_last_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_base == ($clog2(NREG))'(NREG - 1) && rd_wsel == EW64 && rd_idx != '0)
    |-> rd_wrap);

  // R2: element 0 never wraps, on either port
  p_idx0_nowrap_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == '0 && wr_idx == '0) |-> (!rd_wrap && !wr_wrap));
endmodule

bind elem_overlay_rf ovl_checker #(.NREG(NREG), .IDXW(IDXW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_base(wr_base), .wr_idx(wr_idx),
  .wr_wsel(wr_wsel), .wr_data(wr_data), .wr_wrap(wr_wrap),
  .rd_base(rd_base), .rd_idx(rd_idx), .rd_wsel(rd_wsel),
  .rd_data(rd_data), .rd_wrap(rd_wrap)
);

// File: tb/elem_overlay_rf_test.sv
module elem_overlay_rf_test;
  localparam int NREG = 32;
  localparam int IDXW = 8;
  localparam int DW   = 64;
  localparam int FBYTES = NREG * 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [4:0]      wr_base = '0;
  logic [IDXW-1:0] wr_idx = '0;
  logic [1:0]      wr_wsel = '0;
  logic [DW-1:0]   wr_data = '0;
  logic            wr_wrap;
  logic [4:0]      rd_base = '0;
  logic [IDXW-1:0] rd_idx = '0;
  logic [1:0]      rd_wsel = 2'd3;
  logic [DW-1:0]   rd_data;
  logic            rd_wrap;

  elem_overlay_rf #(.NREG(NREG), .IDXW(IDXW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_base(wr_base), .wr_idx(wr_idx),
    .wr_wsel(wr_wsel), .wr_data(wr_data), .wr_wrap(wr_wrap),
    .rd_base(rd_base), .rd_idx(rd_idx), .rd_wsel(rd_wsel),
    .rd_data(rd_data), .rd_wrap(rd_wrap)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    logic [DW-1:0] exp_data;
    logic          exp_wrap;
    bit            is_wr;
    string         tag;
  } item_t;

  item_t      sb[$];
  logic [7:0] mdl [FBYTES];
  int         checks = 0;
  int         fails  = 0;

  function automatic int flat_pos(int base, int idx, int w);
    return base * 8 + idx * (1 << w);
  endfunction

  task automatic clear_model();
    for (int i = 0; i < FBYTES; i++) mdl[i] = 8'h00;
  endtask

  task automatic rd(input int base, input int idx, input int w, input string tag);
    item_t it;
    int    p;
    @(posedge clk); #2;
    rd_base = 5'(base); rd_idx = IDXW'(idx); rd_wsel = 2'(w);
    p = flat_pos(base, idx, w);
    it.exp_data = '0;
    for (int k = 0; k < (1 << w); k++) it.exp_data[8*k +: 8] = mdl[(p + k) % FBYTES];
    it.exp_wrap = (p >= FBYTES);
    it.is_wr    = 1'b0;
    it.tag      = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input int base, input int idx, input int w,
                    input logic [DW-1:0] d, input string tag);
    item_t it;
    int    p;
    @(posedge clk); #2;
    wr_base = 5'(base); wr_idx = IDXW'(idx); wr_wsel = 2'(w); wr_data = d; wr_en = 1'b1;
    p = flat_pos(base, idx, w);
    for (int k = 0; k < (1 << w); k++) mdl[(p + k) % FBYTES] = d[8*k +: 8];
    it.exp_data = '0;
    it.exp_wrap = (p >= FBYTES);
    it.is_wr    = 1'b1;
    it.tag      = tag;
    sb.push_back(it);
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  // drive write inputs with enable low: storage must not change
  task automatic idle_write(input int base, input int w, input logic [DW-1:0] d);
    @(posedge clk); #2;
    wr_base = 5'(base); wr_idx = '0; wr_wsel = 2'(w); wr_data = d; wr_en = 1'b0;
    @(posedge clk); #2;
  endtask

  task automatic do_reset();
    @(posedge clk); #2; rst = 1'b1;
    @(posedge clk); #2; rst = 1'b0;
    clear_model();
  endtask

  // monitor: compare queued expectations mid-cycle
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (it.is_wr) begin
        if (wr_wrap !== it.exp_wrap) begin
          fails++;
          $display("FAIL %s wr_wrap actual=%0b expected=%0b", it.tag, wr_wrap, it.exp_wrap);
        end
      end else if (rd_data !== it.exp_data || rd_wrap !== it.exp_wrap) begin
        fails++;
        $display("FAIL %s rd_data actual=%h/%0b expected=%h/%0b",
                 it.tag, rd_data, rd_wrap, it.exp_data, it.exp_wrap);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    clear_model();
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;

    // R8: reset state
    rd(0, 0, 3, "R8"); rd(5, 0, 3, "R8"); rd(31, 0, 3, "R8");

    // R9: whole-register scalar access
    wr(5, 0, 3, 64'h0123456789ABCDEF, "R9");
    rd(5, 0, 3, "R9");

    // R2: byte elements fill upward from the LSB
    for (int i = 0; i < 8; i++) wr(2, i, 0, DW'(i * 17 + 3), "R2");
    rd(2, 0, 3, "R2"); rd(2, 5, 0, "R2"); rd(2, 1, 1, "R2");

    // R5: narrow write keeps neighbours
    wr(5, 1, 1, 64'hFFFF_FFFF_FFFF_BEEF, "R5");
    rd(5, 0, 3, "R5");

    // R4: zero extension of narrow reads
    rd(5, 7, 0, "R4"); rd(5, 1, 2, "R4"); rd(5, 3, 1, "R4");

    // R1: every width code on the same register
    for (int w = 0; w < 4; w++) rd(5, 0, w, "R1");

    // R3: overflow into following registers, aliasing
    wr(3, 5, 2, 64'h0000_0000_CAFE_D00D, "R3");
    rd(5, 1, 2, "R3"); rd(3, 5, 2, "R3"); rd(4, 3, 2, "R3");
    wr(0, 40, 0, 64'h5A, "R3");
    rd(5, 0, 0, "R3"); rd(5, 0, 3, "R3");
    wr(10, 3, 3, 64'hA5A5_1234_5678_9ABC, "R3");
    rd(13, 0, 3, "R3"); rd(10, 13, 1, "R3");

    // R7: wrap past the last register
    wr(31, 2, 3, 64'hDEAD_BEEF_0BAD_F00D, "R7");
    rd(1, 0, 3, "R7"); rd(31, 2, 3, "R7"); rd(31, 0, 3, "R7");
    rd(0, 255, 3, "R7"); rd(31, 8, 0, "R7");

    // R6: enable low, inputs driven
    idle_write(6, 3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(6, 0, 3, "R6");

    // R5: mixed pseudo-random pattern
    lfsr = 16'hACE1;
    for (int n = 0; n < 24; n++) begin
      int b, i, w;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = int'(lfsr[4:0]); w = int'(lfsr[6:5]); i = int'(lfsr[15:8]) % 40;
      wr(b, i, w, {lfsr, ~lfsr, lfsr ^ 16'h3C3C, lfsr + 16'd7}, "R5");
      rd(b, i, w, "R5");
      rd((b * 8 + i * (1 << w)) / 8 % NREG, 0, 3, "R5");
    end

    // R8: reset clears populated file
    do_reset();
    rd(5, 0, 3, "R8"); rd(1, 0, 3, "R8"); rd(13, 0, 3, "R8");

    @(posedge clk); @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule